// File: doc/BRIEF.md
# Multichannel PWM generator with duty-triggered commit

This block drives up to four independent pulse-width modulated outputs from one input clock. Each channel divides the clock with its own prescaler, counts steps up to its own modulus, and holds its output high while the step count is below its duty value. Software reaches every channel through a small synchronous register port. The port has a write strobe, a read strobe, an address, write data and registered read data.

Prescale and modulus writes only fill staged copies. A write to the duty register marks the whole staged set as pending. A running channel applies that set at the end of its current period, so no period mixes old and new values. A disabled channel applies it at once, and it runs with the new values from the first cycle after it is enabled. Clearing the enable bit stops the channel in the next cycle, with no wait for the period to end.

Top module: `pwm_bank`

## Requirements
- R1: Channel c occupies the 32-byte window starting at byte address c*32. Offset 0x00 is the 8-bit prescale, 0x04 the 8-bit modulus, 0x08 the 16-bit duty and 0x18 the enable flag (bit 0). A read returns the last written (staged) value with all upper bits zero. rdata is loaded at the clock edge that samples rd and holds its value while rd is low.
- R2: Reads of any other offset, or of a channel index at or above the channel count, return zero. Writes to them change nothing.
- R3: After reset every channel is disabled, every register reads zero, nothing is pending and every output is low.
- R4: Step j after enable (j = 0 is the first cycle after the enabling write) has step index floor(j/(P+1)) mod M. The output is high while that index is below D. A period therefore lasts (P+1)*M cycles, with (P+1)*D of them high.
- R5: A duty at or above the modulus gives a constant high output, and a duty of 0 gives a constant low output. A modulus of 0 behaves as a modulus of 1.
- R6: Writes to prescale or modulus have no effect on the output until a duty write follows.
- R7: On a running channel, a duty write commits the staged prescale, modulus and duty at the end of the current period, and the next period starts at step 0 with the new values.
- R8: On a disabled channel, a pending set is applied at once. A later enable then starts with the new values.
- R9: A write of 0 to the enable flag forces the output low from the next cycle, even mid-period. A later enable restarts at step 0.
- R10: Channels run independently. Writes to or disabling of one channel never change another channel's output or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (8) | Byte address of the register access |
| wdata | input | BW (32) | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | BW (32) | Registered read data |
| pwm_o | output | NCH (4) | One PWM output per channel |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit address, 8-bit prescale and modulus, and 16-bit duty. With an 8-bit address the port can reach channel slots 4 to 7 and offsets such as 0x14 that alias mapped ones under partial decoding. This lets the bench check the ignored-access rule against real aliasing targets. The small prescale and modulus values it writes keep each period a few dozen cycles long. Mid-period commits, period-boundary hand-over, immediate stop and two channels running side by side can then all be seen within short windows.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int BW  = 32,
  parameter int PSW = 8,
  parameter int MW  = 8,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [BW-1:0]  wdata,
  input  logic           wr,
  input  logic           rd,
  output logic [BW-1:0]  rdata,
  output logic [NCH-1:0] pwm_o
);
  localparam int SLOT = 5;
  localparam int CW   = AW - SLOT;
  localparam int CMW  = (DW > MW) ? DW : MW;
  localparam logic [SLOT-1:0] O_PS   = 5'h00;
  localparam logic [SLOT-1:0] O_MOD  = 5'h04;
  localparam logic [SLOT-1:0] O_DUTY = 5'h08;
  localparam logic [SLOT-1:0] O_EN   = 5'h18;

  wire [CW-1:0]   csel = addr[AW-1:SLOT];
  wire [SLOT-1:0] off  = addr[SLOT-1:0];

  logic [BW-1:0]  rd_val [NCH];
  logic [NCH-1:0] en_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire hit    = (csel == CW'(g));
    wire w_ps   = wr & hit & (off == O_PS);
    wire w_mod  = wr & hit & (off == O_MOD);
    wire w_duty = wr & hit & (off == O_DUTY);
    wire w_en   = wr & hit & (off == O_EN);

    logic [PSW-1:0] s_ps,  a_ps,  pre;
    logic [MW-1:0]  s_mod, a_mod, step;
    logic [DW-1:0]  s_duty, a_duty;
    logic           en, pend;

    wire [MW-1:0] last    = (a_mod == '0) ? '0 : a_mod - 1'b1;
    wire          pre_end = (pre == a_ps);
    wire          per_end = pre_end && (step == last);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_ps <= '0; s_mod <= '0; s_duty <= '0;
        a_ps <= '0; a_mod <= '0; a_duty <= '0;
        pre <= '0; step <= '0; en <= 1'b0; pend <= 1'b0;
      end else begin
        if (w_ps)   s_ps   <= wdata[PSW-1:0];
        if (w_mod)  s_mod  <= wdata[MW-1:0];
        if (w_duty) s_duty <= wdata[DW-1:0];
        if (w_en)   en     <= wdata[0];
        if (!en) begin
          pre  <= '0;
          step <= '0;
          if (pend) begin
            a_ps <= s_ps; a_mod <= s_mod; a_duty <= s_duty;
            pend <= 1'b0;
          end
        end else if (!pre_end) begin
          pre <= pre + 1'b1;
        end else begin
          pre <= '0;
          if (!per_end) begin
            step <= step + 1'b1;
          end else begin
            step <= '0;
            if (pend) begin
              a_ps <= s_ps; a_mod <= s_mod; a_duty <= s_duty;
              pend <= 1'b0;
            end
          end
        end
        if (w_duty) pend <= 1'b1;
      end
    end

    assign en_q[g]  = en;
    assign pwm_o[g] = en && (CMW'(step) < CMW'(a_duty));

    always_comb begin
      rd_val[g] = '0;
      if (hit) begin
        case (off)
          O_PS:    rd_val[g] = BW'(s_ps);
          O_MOD:   rd_val[g] = BW'(s_mod);
          O_DUTY:  rd_val[g] = BW'(s_duty);
          O_EN:    rd_val[g] = BW'(en);
          default: rd_val[g] = '0;
        endcase
      end
    end
  end

  logic [BW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) rd_mux = rd_mux | rd_val[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

module pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int BW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  addr,
  input logic [BW-1:0]  wdata,
  input logic           wr,
  input logic           rd,
  input logic [BW-1:0]  rdata,
  input logic [NCH-1:0] pwm_o,
  input logic [NCH-1:0] en_vec
);
  localparam int CW = AW - 5;
  wire [CW-1:0] csel = addr[AW-1:5];
  wire [4:0]    off  = addr[4:0];
  wire gap = (off != 5'h00 && off != 5'h04 && off != 5'h08 && off != 5'h18)
             || (int'(csel) >= NCH);

  a_r3_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_o == '0 && rdata == '0));

  a_r1_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && gap) |=> (rdata == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    localparam logic [NCH-1:0] OWN = NCH'(1) << g;

    a_r9_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && csel == CW'(g) && off == 5'h18 && !wdata[0]) |=> !pwm_o[g]);

    a_r10_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && csel == CW'(g)) |=> ((en_vec & ~OWN) == $past(en_vec & ~OWN)));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .pwm_o(pwm_o), .en_vec(en_q)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int BW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [BW-1:0]  wdata = '0;
  logic           wr = 1'b0;
  logic           rd = 1'b0;
  logic [BW-1:0]  rdata;
  logic [NCH-1:0] pwm_o;

  pwm_bank #(.NCH(NCH), .AW(AW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pwm_o(pwm_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [NCH-1:0] exp;
    logic [NCH-1:0] msk;
    string          tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if ((pwm_o & it.msk) !== (it.exp & it.msk)) begin
        n_fail++;
        $display("FAIL %s: pwm_o=%b expected %b (mask %b)", it.tag, pwm_o, it.exp, it.msk);
      end
    end
  end

  function automatic logic wave(int ps, int md, int du, int j);
    int m = (md == 0) ? 1 : md;
    return ((j / (ps + 1)) % m) < du;
  endfunction

  function automatic logic [AW-1:0] ra(int ch, int o);
    return AW'(ch * 32 + o);
  endfunction

  task automatic wr_reg(logic [AW-1:0] a, logic [BW-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [BW-1:0] e, string tag);
    addr = a; rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
    n_chk++;
    if (rdata !== e) begin
      n_fail++;
      $display("FAIL %s: read @%h got %h expected %h", tag, a, rdata, e);
    end
  endtask

  task automatic push_wave(int ch, int ps, int md, int du, int j0, int n, string tag);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.msk = NCH'(1) << ch;
      it.exp = wave(ps, md, du, j0 + k) ? it.msk : '0;
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic push_low(int ch, int n, string tag);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.msk = NCH'(1) << ch;
      it.exp = '0;
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic setup(int ch, int ps, int md, int du);
    wr_reg(ra(ch, 'h00), BW'(ps));
    wr_reg(ra(ch, 'h04), BW'(md));
    wr_reg(ra(ch, 'h08), BW'(du));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R3: reset state
    rd_chk(ra(0, 'h00), 0, "R3 prescale");
    rd_chk(ra(0, 'h04), 0, "R3 modulus");
    rd_chk(ra(3, 'h08), 0, "R3 duty");
    rd_chk(ra(2, 'h18), 0, "R3 enable");
    for (int k = 0; k < 4; k++) begin
      item_t it;
      it.msk = '1; it.exp = '0; it.tag = "R3 outputs low";
      q.push_back(it);
    end
    drain();

    // R1: map, field widths, read hold
    wr_reg(ra(2, 'h00), 32'hFFFF_FF03);
    wr_reg(ra(2, 'h04), 32'h1234_5607);
    wr_reg(ra(2, 'h08), 32'hABCD_0009);
    wr_reg(ra(2, 'h18), 32'hFFFF_FFFE);
    rd_chk(ra(2, 'h00), 32'h03, "R1 prescale field");
    rd_chk(ra(2, 'h04), 32'h07, "R1 modulus field");
    rd_chk(ra(2, 'h18), 32'h00, "R1 enable bit0");
    rd_chk(ra(2, 'h08), 32'h0009, "R1 duty field");
    idle(3);
    n_chk++;
    if (rdata !== 32'h0009) begin
      n_fail++;
      $display("FAIL R1 read hold: got %h expected %h", rdata, 32'h0009);
    end

    // R2: unmapped offsets and channels
    wr_reg(ra(2, 'h14), 32'h55);
    rd_chk(ra(2, 'h04), 32'h07, "R2 alias offset write ignored");
    rd_chk(ra(2, 'h14), 0, "R2 unmapped offset reads zero");
    wr_reg(ra(5, 'h04), 32'h66);
    rd_chk(ra(1, 'h04), 0, "R2 alias channel write ignored");
    rd_chk(ra(5, 'h04), 0, "R2 unmapped channel reads zero");

    // R4, R8: basic waveform, idle commit then enable
    setup(0, 1, 4, 1);
    wr_reg(ra(0, 'h18), 1);
    push_wave(0, 1, 4, 1, 0, 24, "R4 period and high time");
    drain();
    wr_reg(ra(0, 'h18), 0);

    // R5: constant high, constant low, modulus 0
    setup(1, 0, 5, 5);
    wr_reg(ra(1, 'h18), 1);
    push_wave(1, 0, 5, 5, 0, 12, "R5 duty equal modulus high");
    drain();
    wr_reg(ra(1, 'h18), 0);
    wr_reg(ra(1, 'h08), 0);
    wr_reg(ra(1, 'h18), 1);
    push_low(1, 12, "R5 duty zero low");
    drain();
    wr_reg(ra(1, 'h18), 0);
    setup(1, 0, 0, 1);
    wr_reg(ra(1, 'h18), 1);
    push_wave(1, 0, 0, 1, 0, 10, "R5 modulus zero as one");
    drain();
    wr_reg(ra(1, 'h18), 0);

    // R6, R7: staged writes, commit at period end
    setup(0, 0, 4, 2);
    wr_reg(ra(0, 'h18), 1);
    push_wave(0, 0, 4, 2, 0, 20, "R6 staged writes no effect");
    push_wave(0, 2, 7, 3, 0, 42, "R7 commit at period end");
    wr_reg(ra(0, 'h04), 7);
    wr_reg(ra(0, 'h00), 2);
    idle(15);
    wr_reg(ra(0, 'h08), 3);
    drain();
    wr_reg(ra(0, 'h18), 0);

    // R9: immediate stop, restart at step 0
    setup(0, 0, 10, 8);
    wr_reg(ra(0, 'h18), 1);
    push_wave(0, 0, 10, 8, 0, 5, "R9 before stop");
    push_low(0, 6, "R9 stop mid-period");
    idle(4);
    wr_reg(ra(0, 'h18), 0);
    drain();
    wr_reg(ra(0, 'h18), 1);
    push_wave(0, 0, 10, 8, 0, 12, "R9 restart at step 0");
    drain();
    wr_reg(ra(0, 'h18), 0);

    // R8: new set written while disabled starts on enable
    wr_reg(ra(0, 'h08), 3);
    wr_reg(ra(0, 'h18), 1);
    push_wave(0, 0, 10, 3, 0, 12, "R8 idle commit");
    drain();
    wr_reg(ra(0, 'h18), 0);

    // R10: independent channels
    setup(0, 0, 3, 1);
    setup(3, 1, 5, 3);
    wr_reg(ra(0, 'h18), 1);
    wr_reg(ra(3, 'h18), 1);
    for (int k = 0; k < 30; k++) begin
      item_t it;
      it.msk = 4'b1001;
      it.exp = '0;
      it.exp[0] = wave(0, 3, 1, k + 1);
      it.exp[3] = (k < 15) ? wave(1, 5, 3, k) : 1'b0;
      it.tag = "R10 channels independent";
      q.push_back(it);
    end
    idle(14);
    wr_reg(ra(3, 'h18), 0);
    drain();
    rd_chk(ra(0, 'h18), 1, "R10 other channel still enabled");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule